// File: doc/BRIEF.md
# Gate and Fast-Clear Sequencer

This block runs the acquisition phase of a multichannel charge-integrating digitizer. A gate can come from an external level input or from a single-cycle software strobe that produces a fixed-length gate. While the accepted gate is high, the block drives an integrate-enable output. The enable starts a programmed number of cycles after the gate is accepted and drops on the gate's trailing edge.

When the gate ends, a fast-clear window opens. A 3-bit window selector picks the window source. A nonzero value runs an internal timer for the selector value times a base count. Zero hands the window to an external controller's level input. A fast clear inside the window discards the event. If the window closes without a clear, the block waits for the conversion-done input and then commits the event with a one-cycle pulse to the event buffer.

The busy output is high from gate acceptance until the outcome. It is also high whenever the event buffer reports full. Gate requests that arrive while busy are dropped, and a sticky flag records each such overlap.

Top module: `acq_gate_seq`

## Requirements
- R1: After reset, with buf_full_i low, busy_o, integ_en_o, win_open_o, commit_o, discard_o and overlap_o are all 0.
- R2: A gate request is a rising edge of the synchronized ext_gate_i or a sw_gate_i strobe. It is accepted only while gate_en_i is 1, the block is idle and buf_full_i is 0. With gate_en_i at 0, requests leave all outputs at 0 and do not set overlap_o.
- R3: An accepted sw_gate_i strobe produces an internal gate that is high for exactly SW_GATE_CYCLES cycles.
- R4: integ_en_o rises INTEG_DLY cycles after acceptance and falls with the gate. It is high for SW_GATE_CYCLES−INTEG_DLY cycles on a software gate. On an external gate held L cycles it is high for max(0, L−1−INTEG_DLY) cycles.
- R5: With a nonzero selector, win_open_o is high for exactly selector×WIN_BASE cycles after the gate ends. The selector is latched at gate acceptance, so later changes do not affect the current event.
- R6: With selector 0, the window stays open while ext_win_i is 1 and closes at the first clock edge that samples it 0.
- R7: fast_clear_i sampled high during any window cycle, including the last one, closes the window at that edge. It then gives one discard_o pulse and no commit_o.
- R8: A window that ends without a clear leads to exactly one commit_o pulse, one cycle after conv_done_i is sampled high. fast_clear_i after the window has no effect.
- R9: busy_o is 1 whenever buf_full_i is 1. While the buffer is full no gate is taken, and gates are taken again once it drops.
- R10: A request while gate_en_i is 1 and busy_o is 1 is ignored and sets overlap_o. overlap_o stays set until rst_ni is asserted.
- R11: Each accepted gate ends in exactly one of commit_o or discard_o, and never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_en_i | input | 1 | Enables gate acceptance |
| ext_gate_i | input | 1 | External gate level, asynchronous |
| sw_gate_i | input | 1 | Software strobe that starts a fixed-length gate |
| win_sel_i | input | SEL_W | Window selector; 0 selects the external window |
| ext_win_i | input | 1 | External window level, used when the selector is 0 |
| fast_clear_i | input | 1 | Fast clear request |
| conv_done_i | input | 1 | Conversion finished |
| buf_full_i | input | 1 | Event buffer full |
| integ_en_o | output | 1 | Integrate enable to the front end |
| win_open_o | output | 1 | Fast-clear window is open |
| busy_o | output | 1 | Conversion in progress; blocks gates |
| commit_o | output | 1 | One-cycle pulse: store the event |
| discard_o | output | 1 | One-cycle pulse: event dropped |
| overlap_o | output | 1 | Sticky flag: a gate arrived while busy |

## Verification
The bench builds the block with SW_GATE_CYCLES=8, INTEG_DLY=2, WIN_BASE=2 and a two-stage synchronizer. These small values make every window length from 2 to 14 cycles cheap to sweep. The bench places a fast clear on each cycle of one window, including the final one, and sweeps external gate lengths across the integration-delay boundary. The small values also keep the latched selector, the external window and the full-buffer stall short enough to check cycle by cycle against arithmetic expectations.

// File: rtl/acq_gate_seq_pkg.sv
package acq_gate_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GATE,
    ST_WIN,
    ST_CONV
  } seq_state_e;
endpackage

// File: rtl/acq_gate_src.sv
module acq_gate_src #(
  parameter int SYNC_STAGES    = 2,
  parameter int SW_GATE_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_gate_i,
  input  logic sw_gate_i,
  input  logic arm_i,
  output logic req_o,
  output logic gate_rise_o,
  output logic gate_lvl_o
);
  localparam int SW_W = $clog2(SW_GATE_CYCLES + 1);
  localparam logic [SW_W-1:0] SW_LEN = SW_W'(SW_GATE_CYCLES);

  logic ext_s, ext_d_q, ext_edge;
  logic [SW_W-1:0] sw_cnt_q;
  logic sw_active;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign ext_s = ext_gate_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_gate_i};
      end
      assign ext_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d_q <= 1'b0;
    else         ext_d_q <= ext_s;
  end

  assign ext_edge = ext_s & ~ext_d_q;

  // fixed-length software gate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sw_cnt_q <= '0;
    else if (sw_gate_i && arm_i)  sw_cnt_q <= SW_LEN;
    else if (sw_cnt_q != '0)      sw_cnt_q <= sw_cnt_q - 1'b1;
  end

  assign sw_active   = (sw_cnt_q != '0);
  assign req_o       = ext_edge | sw_gate_i;
  assign gate_rise_o = arm_i & req_o;
  assign gate_lvl_o  = ext_s | sw_active;

  p_sw_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_cnt_q != '0) |=> (sw_cnt_q == $past(sw_cnt_q) - 1'b1));

  p_sw_no_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_active |-> !arm_i);
endmodule

// File: rtl/acq_win_timer.sv
module acq_win_timer #(
  parameter int SEL_W    = 3,
  parameter int WIN_BASE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  input  logic             ext_win_i,
  output logic             done_o
);
  localparam int MAX_WIN = ((1 << SEL_W) - 1) * WIN_BASE;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [CNT_W-1:0] BASE_C = CNT_W'(WIN_BASE);

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ext_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sel_q <= sel_i;
      cnt_q <= CNT_W'(sel_i) * BASE_C;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ext_mode = (sel_q == '0);
  assign done_o   = run_i & (ext_mode ? ~ext_win_i : (cnt_q == CNT_W'(1)));

  p_win_cnt_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ext_mode) |-> (cnt_q != '0));

  p_sel_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(sel_q));
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_gate_seq_pkg::*;
#(
  parameter int INTEG_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_en_i,
  input  logic buf_full_i,
  input  logic req_i,
  input  logic gate_rise_i,
  input  logic gate_lvl_i,
  input  logic fast_clear_i,
  input  logic conv_done_i,
  input  logic win_done_i,
  output logic arm_o,
  output logic load_o,
  output logic win_run_o,
  output logic integ_en_o,
  output logic busy_o,
  output logic commit_o,
  output logic discard_o,
  output logic overlap_o
);
  localparam int DLY_W = (INTEG_DLY < 1) ? 1 : $clog2(INTEG_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_C = DLY_W'(INTEG_DLY);

  seq_state_e state_q, state_d;
  logic [DLY_W-1:0] dly_q;
  logic commit_q, discard_q, overlap_q;

  assign arm_o      = (state_q == ST_IDLE) & gate_en_i & ~buf_full_i;
  assign busy_o     = (state_q != ST_IDLE) | buf_full_i;
  assign load_o     = gate_rise_i;
  assign win_run_o  = (state_q == ST_WIN);
  assign integ_en_o = (state_q == ST_GATE) & gate_lvl_i & (dly_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (gate_rise_i)  state_d = ST_GATE;
      ST_GATE: if (!gate_lvl_i)  state_d = ST_WIN;
      ST_WIN: begin
        if (fast_clear_i)        state_d = ST_IDLE;  // clear wins over window end
        else if (win_done_i)     state_d = ST_CONV;
      end
      ST_CONV: if (conv_done_i)  state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      dly_q     <= '0;
      commit_q  <= 1'b0;
      discard_q <= 1'b0;
      overlap_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      commit_q  <= (state_q == ST_CONV) & conv_done_i;
      discard_q <= (state_q == ST_WIN) & fast_clear_i;
      overlap_q <= overlap_q | (gate_en_i & busy_o & req_i);
      if (gate_rise_i)                               dly_q <= DLY_C;
      else if (state_q == ST_GATE && dly_q != '0)    dly_q <= dly_q - 1'b1;
    end
  end

  assign commit_o  = commit_q;
  assign discard_o = discard_q;
  assign overlap_o = overlap_q;

  p_outcome_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && discard_o));

  p_full_holds_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && buf_full_i) |=> (state_q == ST_IDLE));

  p_discard_to_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> (state_q == ST_IDLE));

  p_overlap_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_o |=> overlap_o);

  generate
    if (INTEG_DLY > 0) begin : g_dly_chk
      p_integ_after_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        integ_en_o |-> $past(busy_o));
    end
  endgenerate
endmodule

// File: rtl/acq_gate_seq.sv
module acq_gate_seq #(
  parameter int SYNC_STAGES    = 2,
  parameter int SW_GATE_CYCLES = 100,
  parameter int INTEG_DLY      = 4,
  parameter int WIN_BASE       = 16,
  parameter int SEL_W          = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_en_i,
  input  logic             ext_gate_i,
  input  logic             sw_gate_i,
  input  logic [SEL_W-1:0] win_sel_i,
  input  logic             ext_win_i,
  input  logic             fast_clear_i,
  input  logic             conv_done_i,
  input  logic             buf_full_i,
  output logic             integ_en_o,
  output logic             win_open_o,
  output logic             busy_o,
  output logic             commit_o,
  output logic             discard_o,
  output logic             overlap_o
);
  logic arm, req, gate_rise, gate_lvl, load, win_run, win_done;

  acq_gate_src #(
    .SYNC_STAGES   (SYNC_STAGES),
    .SW_GATE_CYCLES(SW_GATE_CYCLES)
  ) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_gate_i (ext_gate_i),
    .sw_gate_i  (sw_gate_i),
    .arm_i      (arm),
    .req_o      (req),
    .gate_rise_o(gate_rise),
    .gate_lvl_o (gate_lvl)
  );

  acq_win_timer #(
    .SEL_W   (SEL_W),
    .WIN_BASE(WIN_BASE)
  ) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .sel_i    (win_sel_i),
    .run_i    (win_run),
    .ext_win_i(ext_win_i),
    .done_o   (win_done)
  );

  acq_seq_fsm #(
    .INTEG_DLY(INTEG_DLY)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gate_en_i   (gate_en_i),
    .buf_full_i  (buf_full_i),
    .req_i       (req),
    .gate_rise_i (gate_rise),
    .gate_lvl_i  (gate_lvl),
    .fast_clear_i(fast_clear_i),
    .conv_done_i (conv_done_i),
    .win_done_i  (win_done),
    .arm_o       (arm),
    .load_o      (load),
    .win_run_o   (win_run),
    .integ_en_o  (integ_en_o),
    .busy_o      (busy_o),
    .commit_o    (commit_o),
    .discard_o   (discard_o),
    .overlap_o   (overlap_o)
  );

  assign win_open_o = win_run;

  p_full_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full_i && !$past(busy_o)) |=> !integ_en_o);
endmodule

// File: tb/acq_gate_seq_tb.sv
module acq_gate_seq_tb;
  localparam int SYNC = 2;
  localparam int SWC  = 8;
  localparam int DLY  = 2;
  localparam int BASE = 2;
  localparam int SELW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic gate_en = 1'b0, ext_gate = 1'b0, sw_gate = 1'b0, ext_win = 1'b0;
  logic fast_clear = 1'b0, conv_done = 1'b0, buf_full = 1'b0;
  logic [SELW-1:0] win_sel = '0;
  logic integ_en, win_open, busy, commit, discard, overlap;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  acq_gate_seq #(
    .SYNC_STAGES(SYNC), .SW_GATE_CYCLES(SWC), .INTEG_DLY(DLY),
    .WIN_BASE(BASE), .SEL_W(SELW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .gate_en_i(gate_en), .ext_gate_i(ext_gate),
    .sw_gate_i(sw_gate), .win_sel_i(win_sel), .ext_win_i(ext_win),
    .fast_clear_i(fast_clear), .conv_done_i(conv_done), .buf_full_i(buf_full),
    .integ_en_o(integ_en), .win_open_o(win_open), .busy_o(busy),
    .commit_o(commit), .discard_o(discard), .overlap_o(overlap)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one event: fc_pos >=0 clears in that window cycle, -2 clears after window
  task automatic run_evt(input bit use_sw, input int glen, input int sel,
                         input int fc_pos, input int ewin, input bit poke,
                         output int n_int, output int n_win,
                         output int n_com, output int n_dis);
    int post;
    bit seen_win, done;
    n_int = 0; n_win = 0; n_com = 0; n_dis = 0;
    post = 0; seen_win = 0; done = 0;
    @(negedge clk);
    win_sel = SELW'(sel);
    ext_win = (ewin > 0);
    if (use_sw) sw_gate = 1'b1; else ext_gate = 1'b1;
    for (int c = 0; c < 400 && !done; c++) begin
      @(negedge clk);
      sw_gate = 1'b0;
      fast_clear = 1'b0;
      if (!use_sw && c + 1 >= glen) ext_gate = 1'b0;
      n_int += int'(integ_en);
      n_com += int'(commit);
      n_dis += int'(discard);
      if (win_open) begin
        if (poke && n_win == 0) begin
          sw_gate = 1'b1;
          win_sel = SELW'(sel + 3);
        end
        if (n_win == fc_pos) fast_clear = 1'b1;
        n_win++;
        if (ewin > 0 && n_win >= ewin) ext_win = 1'b0;
        seen_win = 1;
      end else if (seen_win && n_dis == 0) begin
        post++;
        if (fc_pos == -2) fast_clear = 1'b1;
        if (post >= 3) conv_done = 1'b1;
      end
      if (n_com + n_dis > 0) done = 1;
    end
    conv_done = 1'b0; fast_clear = 1'b0; sw_gate = 1'b0;
    ext_gate = 1'b0; ext_win = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int ni, nw, nc, nd, cnt_b, cnt_i, cnt_w, cnt_c;
    do_reset();
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 integ", int'(integ_en), 0);
    chk("R1 win", int'(win_open), 0);
    chk("R1 commit", int'(commit), 0);
    chk("R1 discard", int'(discard), 0);
    chk("R1 overlap", int'(overlap), 0);

    // R2 disabled gate ignored
    gate_en = 1'b0;
    cnt_b = 0; cnt_i = 0; cnt_w = 0; cnt_c = 0;
    @(negedge clk); sw_gate = 1'b1; ext_gate = 1'b1;
    @(negedge clk); sw_gate = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (c == 5) ext_gate = 1'b0;
      cnt_b += int'(busy); cnt_i += int'(integ_en);
      cnt_w += int'(win_open); cnt_c += int'(commit) + int'(discard);
    end
    chk("R2 disabled busy", cnt_b, 0);
    chk("R2 disabled integ", cnt_i, 0);
    chk("R2 disabled window", cnt_w, 0);
    chk("R2 disabled outcome", cnt_c, 0);
    chk("R2 disabled overlap", int'(overlap), 0);
    gate_en = 1'b1;

    // R3 R4 R5 R8: software gate, every internal window length
    for (int s = 1; s < 8; s++) begin
      run_evt(1'b1, 0, s, -1, 0, 1'b0, ni, nw, nc, nd);
      chk("R3 R4 sw integ cycles", ni, SWC - DLY);
      chk("R5 window cycles", nw, s * BASE);
      chk("R8 commit", nc, 1);
      chk("R11 no discard", nd, 0);
    end

    // R7 R11: clear on every window cycle, last included
    for (int f = 0; f < 3 * BASE; f++) begin
      run_evt(1'b1, 0, 3, f, 0, 1'b0, ni, nw, nc, nd);
      chk("R7 window cut", nw, f + 1);
      chk("R7 discard", nd, 1);
      chk("R7 no commit", nc, 0);
      chk("R11 single outcome", nc + nd, 1);
    end

    // R8 clear after window ignored
    run_evt(1'b1, 0, 2, -2, 0, 1'b0, ni, nw, nc, nd);
    chk("R8 late clear commit", nc, 1);
    chk("R8 late clear no discard", nd, 0);

    // R2 R4 external gate lengths
    for (int l = 1; l < 9; l++) begin
      run_evt(1'b0, l, 1, -1, 0, 1'b0, ni, nw, nc, nd);
      chk("R4 ext integ cycles", ni, (l - 1 - DLY > 0) ? l - 1 - DLY : 0);
      chk("R2 ext accepted", nc, 1);
      chk("R5 ext window", nw, BASE);
    end

    // R6 external window
    for (int w = 1; w < 6; w++) begin
      run_evt(1'b1, 0, 0, -1, w, 1'b0, ni, nw, nc, nd);
      chk("R6 ext window cycles", nw, w);
      chk("R6 commit", nc, 1);
    end

    // R5 latch, R10 overlap during event
    chk("R10 no overlap yet", int'(overlap), 0);
    run_evt(1'b1, 0, 2, -1, 0, 1'b1, ni, nw, nc, nd);
    chk("R5 selector latched", nw, 2 * BASE);
    chk("R10 overlapped event commits once", nc, 1);
    chk("R10 overlap set", int'(overlap), 1);
    repeat (10) @(negedge clk);
    chk("R10 overlap sticky", int'(overlap), 1);

    // R10 cleared by reset; R9 full buffer
    do_reset();
    chk("R10 overlap cleared", int'(overlap), 0);
    buf_full = 1'b1;
    @(negedge clk);
    chk("R9 busy when full", int'(busy), 1);
    cnt_i = 0; cnt_w = 0; cnt_c = 0;
    sw_gate = 1'b1;
    @(negedge clk); sw_gate = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      cnt_i += int'(integ_en); cnt_w += int'(win_open);
      cnt_c += int'(commit) + int'(discard);
    end
    chk("R9 full no integ", cnt_i, 0);
    chk("R9 full no window", cnt_w, 0);
    chk("R9 full no outcome", cnt_c, 0);
    chk("R10 full overlap", int'(overlap), 1);
    buf_full = 1'b0;
    @(negedge clk);
    chk("R9 busy released", int'(busy), 0);
    run_evt(1'b1, 0, 1, -1, 0, 1'b0, ni, nw, nc, nd);
    chk("R9 accepts after full", nc, 1);
    chk("R9 integ after full", ni, SWC - DLY);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule